// File: doc/BRIEF.md
# Power-Fail Shadow Copy Controller

This controller sequences the transfer of a volatile SRAM image into a nonvolatile shadow array and back again, driven only by two digitised supply-monitor flags. One flag reports that the supply is above the switch-over threshold. The other reports that it has dropped under the lower reset threshold. It watches accepted SRAM writes to know whether the image has changed. It accepts a software store request. It hands start commands to an external array model and waits for that model's done pulse or for a timeout.

A copy into the shadow array is preceded by a short grace interval, so that a bus access already under way can complete. While any nonvolatile cycle runs, host chip-enable requests are withheld from the SRAM. The part is also kept out of standby until the cycle finishes. A recall is armed at reset and whenever the supply falls under the reset threshold. It runs when the supply climbs back over the switch threshold. A shallow dip therefore produces a store but no recall. An unchanged image is never written back automatically.

Top module: `nv_shadow_ctrl`

## Requirements
- R1: After reset, busy, dirty, store_start and recall_start are 0, recall_pending is 1, and ce_out is 0 whatever ce_in is.
- R2: A write is accepted in a cycle where sram_we and ce_out are both 1. An accepted write sets dirty at the following clock edge.
- R3: If the controller is idle, no recall is due, sup_above_sw is 0 and dirty is 1, busy rises at the next edge. store_start then pulses for one cycle exactly GRACE_CYC cycles after busy rose.
- R4: With dirty at 0 and no software request, a low sup_above_sw starts no store, and busy stays 0.
- R5: A sw_store_req pulse while idle starts a store through the same grace interval, even when dirty is 0 and the supply is good.
- R6: A store ends at the edge that samples store_done during the store phase, or after STORE_CYC store-phase cycles without it. At that edge busy falls and dirty is 0.
- R7: sup_below_rst sets recall_pending. When the controller is idle with recall_pending at 1 and sup_above_sw at 1, recall_start pulses one cycle after the next edge. Busy then holds until recall_done is sampled, or for RESTORE_CYC cycles. At the end, recall_pending and dirty are cleared. A due recall takes priority over a store.
- R8: A supply dip that lowers sup_above_sw but never raises sup_below_rst leaves recall_pending at 0, and no recall follows recovery.
- R9: ce_out equals ce_in only while the controller is idle, no recall is pending and sup_above_sw is 1. Otherwise ce_out is 0.
- R10: standby is 1 exactly when ce_in is 0 and busy is 0. A nonvolatile cycle holds standby at 0.
- R11: A sw_store_req that arrives while a cycle runs is remembered. A further store begins one cycle after the current cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (power-up state) |
| sup_above_sw | input | 1 | Supply above switch-over threshold |
| sup_below_rst | input | 1 | Supply under reset threshold |
| ce_in | input | 1 | Host chip-enable request |
| sram_we | input | 1 | Host SRAM write strobe |
| sw_store_req | input | 1 | Software store request pulse |
| store_done | input | 1 | Array model reports store finished |
| recall_done | input | 1 | Array model reports recall finished |
| ce_out | output | 1 | Gated chip enable to the SRAM |
| standby | output | 1 | Low-power state permitted |
| busy | output | 1 | Nonvolatile cycle (grace, store or recall) in progress |
| store_start | output | 1 | One-cycle store command to the array |
| recall_start | output | 1 | One-cycle recall command to the array |
| dirty | output | 1 | SRAM image changed since last store or recall |
| recall_pending | output | 1 | Recall request latched |

## Verification
A corrupted dirty flag shows one edge after the fault, either as a store that begins when the image is clean or as a missing store on a supply drop. A stuck recall latch keeps ce_out at 0 after power returns, and it starts a spurious recall at the first good-supply edge. A miscounted timer shifts store_start away from GRACE_CYC cycles after busy rises, or changes how long busy stays high on a timeout. A lost software request shows as busy staying low one cycle after the current cycle ends.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [1:0] {
        NV_IDLE   = 2'd0,
        NV_GRACE  = 2'd1,
        NV_STORE  = 2'd2,
        NV_RECALL = 2'd3
    } nv_state_e;

    typedef struct packed {
        logic dirty;
        logic rcl_pend;
        logic sw_pend;
    } nv_flags_t;

endpackage

// File: rtl/nvs_cycle_timer.sv
module nvs_cycle_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    output logic [CW-1:0] cnt_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/nvs_flag_bank.sv
module nvs_flag_bank
    import nvs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_acc_i,
    input  logic below_rst_i,
    input  logic sw_req_i,
    input  logic sw_take_i,
    input  logic store_fin_i,
    input  logic recall_fin_i,
    output logic dirty_o,
    output logic rcl_pend_o,
    output logic sw_pend_o
);
    nv_flags_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        // completion of either cycle leaves a clean image
        if (store_fin_i || recall_fin_i) fl_d.dirty = 1'b0;
        if (wr_acc_i)                    fl_d.dirty = 1'b1;
        // a deep dip re-arms the recall; setting wins over clearing
        if (recall_fin_i)                fl_d.rcl_pend = 1'b0;
        if (below_rst_i)                 fl_d.rcl_pend = 1'b1;
        // software requests queue until a store consumes them
        fl_d.sw_pend = (fl_q.sw_pend || sw_req_i) && !sw_take_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q.dirty    <= 1'b0;
            fl_q.rcl_pend <= 1'b1;
            fl_q.sw_pend  <= 1'b0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign dirty_o    = fl_q.dirty;
    assign rcl_pend_o = fl_q.rcl_pend;
    assign sw_pend_o  = fl_q.sw_pend;

    // R8: without a deep dip the recall latch cannot arm itself
    a_r8_no_shallow_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (!below_rst_i && !fl_q.rcl_pend) |=> !fl_q.rcl_pend);

    // R2: an accepted write is remembered
    a_r2_write_marks: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc_i |=> fl_q.dirty);

    // R11: a request seen while no store is taken stays queued
    a_r11_req_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req_i && !sw_take_i) |=> fl_q.sw_pend);
endmodule

// File: rtl/nv_shadow_ctrl.sv
module nv_shadow_ctrl
    import nvs_pkg::*;
#(
    parameter int GRACE_CYC   = 125,
    parameter int STORE_CYC   = 1250000,
    parameter int RESTORE_CYC = 68750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_above_sw,
    input  logic sup_below_rst,
    input  logic ce_in,
    input  logic sram_we,
    input  logic sw_store_req,
    input  logic store_done,
    input  logic recall_done,
    output logic ce_out,
    output logic standby,
    output logic busy,
    output logic store_start,
    output logic recall_start,
    output logic dirty,
    output logic recall_pending
);
    localparam int MAX_A = (GRACE_CYC > STORE_CYC) ? GRACE_CYC : STORE_CYC;
    localparam int MAX_C = (MAX_A > RESTORE_CYC) ? MAX_A : RESTORE_CYC;
    localparam int CW    = $clog2(MAX_C + 1);
    localparam logic [CW-1:0] GRACE_LAST   = CW'(GRACE_CYC - 1);
    localparam logic [CW-1:0] STORE_LAST   = CW'(STORE_CYC - 1);
    localparam logic [CW-1:0] RESTORE_LAST = CW'(RESTORE_CYC - 1);

    nv_state_e     state_d, state_q;
    logic [CW-1:0] cnt;
    logic          tmr_clr, sw_take, store_fin, recall_fin;
    logic          sw_pend, wr_acc, idle;

    assign idle   = (state_q == NV_IDLE);
    assign busy   = !idle;
    assign ce_out = ce_in && idle && !recall_pending && sup_above_sw;
    assign wr_acc = sram_we && ce_out;
    assign standby      = !ce_in && !busy;
    assign store_start  = (state_q == NV_STORE)  && (cnt == '0);
    assign recall_start = (state_q == NV_RECALL) && (cnt == '0);

    always_comb begin
        state_d    = state_q;
        tmr_clr    = 1'b0;
        sw_take    = 1'b0;
        store_fin  = 1'b0;
        recall_fin = 1'b0;
        unique case (state_q)
            NV_IDLE: begin
                tmr_clr = 1'b1;
                if (recall_pending && sup_above_sw) begin
                    state_d = NV_RECALL;
                end else if (sw_pend || sw_store_req || (!sup_above_sw && dirty)) begin
                    state_d = NV_GRACE;
                    sw_take = 1'b1;
                end
            end
            NV_GRACE: begin
                if (cnt == GRACE_LAST) begin
                    state_d = NV_STORE;
                    tmr_clr = 1'b1;
                end
            end
            NV_STORE: begin
                if (store_done || cnt == STORE_LAST) begin
                    state_d   = NV_IDLE;
                    store_fin = 1'b1;
                end
            end
            NV_RECALL: begin
                if (recall_done || cnt == RESTORE_LAST) begin
                    state_d    = NV_IDLE;
                    recall_fin = 1'b1;
                end
            end
            default: state_d = NV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= NV_IDLE;
        else        state_q <= state_d;
    end

    nvs_cycle_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tmr_clr),
        .cnt_o (cnt)
    );

    nvs_flag_bank u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_acc_i     (wr_acc),
        .below_rst_i  (sup_below_rst),
        .sw_req_i     (sw_store_req),
        .sw_take_i    (sw_take),
        .store_fin_i  (store_fin),
        .recall_fin_i (recall_fin),
        .dirty_o      (dirty),
        .rcl_pend_o   (recall_pending),
        .sw_pend_o    (sw_pend)
    );

    // R9: SRAM is fenced off during any nonvolatile cycle
    a_r9_ce_fenced: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ce_out);

    // R10: no standby while a cycle is running
    a_r10_no_standby: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_in && busy) |-> !standby);

    // R6: a finished cycle leaves the image marked clean
    a_r6_clean_after: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !dirty);

    // R3: the store command is preceded by the grace phase
    a_r3_grace_first: assert property (@(posedge clk) disable iff (!rst_n)
        store_start |-> $past(busy));

    // R7: a recall is only issued on a latched request
    a_r7_recall_latched: assert property (@(posedge clk) disable iff (!rst_n)
        recall_start |-> $past(recall_pending));

    // R7: the two commands never overlap
    a_r7_cmd_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_start, recall_start}));

    // R6: the store phase never outlives its timeout
    a_r6_store_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == NV_STORE) |-> (cnt <= STORE_LAST));
endmodule

// File: tb/nv_shadow_ctrl_bench.sv
module nv_shadow_ctrl_bench;
    localparam int G  = 4;
    localparam int S  = 40;
    localparam int RT = 30;

    logic clk = 1'b0;
    logic rst_n, above, below, ce_in, we, sw_req, st_done, rc_done;
    logic ce_out, standby, busy, st_start, rc_start, dirty, rcl_pend;
    int   errors = 0;
    int   checks = 0;

    always #4 clk = ~clk;

    nv_shadow_ctrl #(.GRACE_CYC(G), .STORE_CYC(S), .RESTORE_CYC(RT)) u_nv_shadow_ctrl (
        .clk(clk), .rst_n(rst_n), .sup_above_sw(above), .sup_below_rst(below),
        .ce_in(ce_in), .sram_we(we), .sw_store_req(sw_req),
        .store_done(st_done), .recall_done(rc_done),
        .ce_out(ce_out), .standby(standby), .busy(busy),
        .store_start(st_start), .recall_start(rc_start),
        .dirty(dirty), .recall_pending(rcl_pend)
    );

    // {ce_in, above, expected ce_out, expected standby}  (R9, R10 while idle)
    localparam logic [3:0] VEC [0:3] = '{4'b1110, 4'b0101, 4'b1000, 4'b0001};

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_busy_low(output int n);
        n = 0;
        while (busy && n < 500) begin
            step();
            n++;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        rst_n = 0; above = 0; below = 1; ce_in = 1; we = 0;
        sw_req = 0; st_done = 0; rc_done = 0;
        repeat (3) step();
        rst_n = 1;
        step();
        // R1 power-up state
        chk("R1 busy", busy, 0);
        chk("R1 recall_pending", rcl_pend, 1);
        chk("R1 dirty", dirty, 0);
        chk("R1 ce_out", ce_out, 0);
        chk("R1 starts", st_start | rc_start, 0);

        // R7 recall on supply return, ended by recall_done
        below = 0; above = 1;
        step();
        chk("R7 recall_start", rc_start, 1);
        chk("R7 busy", busy, 1);
        step();
        chk("R7 start one cycle", rc_start, 0);
        rc_done = 1;
        step();
        rc_done = 0;
        chk("R7 done busy", busy, 0);
        chk("R7 latch cleared", rcl_pend, 0);

        // R9/R10 vector walk while idle and clean
        for (int i = 0; i < 4; i++) begin
            ce_in = VEC[i][3];
            above = VEC[i][2];
            #1;
            chk("R9 ce_out", ce_out, VEC[i][1]);
            chk("R10 standby", standby, VEC[i][0]);
            step();
        end

        // R4 clean image: low supply starts nothing
        ce_in = 0; above = 0;
        repeat (6) step();
        chk("R4 no store", busy, 0);

        // R2 accepted write
        above = 1; ce_in = 1; we = 1;
        step();
        we = 0;
        chk("R2 dirty", dirty, 1);

        // R3 automatic store with grace interval
        above = 0;
        step();
        chk("R3 busy", busy, 1);
        chk("R3 no early start", st_start, 0);
        for (int i = 2; i <= G; i++) begin
            step();
            chk("R3 grace", st_start, 0);
        end
        step();
        chk("R3 store_start", st_start, 1);
        ce_in = 1;
        #1;
        chk("R9 fenced", ce_out, 0);
        ce_in = 0;
        #1;
        chk("R10 held", standby, 0);
        st_done = 1;
        step();
        st_done = 0;
        chk("R6 done busy", busy, 0);
        chk("R6 dirty cleared", dirty, 0);

        // R8 shallow dip recovery: no recall
        above = 1;
        repeat (4) step();
        chk("R8 no recall", busy, 0);
        chk("R8 latch", rcl_pend, 0);

        // R5 software store on clean image, R6 timeout length
        sw_req = 1;
        step();
        sw_req = 0;
        chk("R5 sw busy", busy, 1);
        wait_busy_low(n);
        chk("R6 timeout cycles", n, G + S);

        // R11 request during a running cycle
        sw_req = 1;
        step();
        sw_req = 0;
        step();
        sw_req = 1;
        step();
        sw_req = 0;
        n = 0;
        while (!st_start && n < 100) begin
            step();
            n++;
        end
        st_done = 1;
        step();
        st_done = 0;
        chk("R11 gap", busy, 0);
        step();
        chk("R11 serviced", busy, 1);
        wait_busy_low(n);

        // R7 deep dip: store first, latch, then recall by timeout
        ce_in = 1; we = 1;
        step();
        we = 0; ce_in = 0;
        chk("R2 dirty again", dirty, 1);
        above = 0; below = 1;
        step();
        chk("R7 latch set", rcl_pend, 1);
        chk("R3 store on dip", busy, 1);
        n = 0;
        while (!st_start && n < 100) begin
            step();
            n++;
        end
        st_done = 1;
        step();
        st_done = 0;
        below = 0; above = 1;
        step();
        chk("R7 recall_start", rc_start, 1);
        wait_busy_low(n);
        chk("R7 restore timeout", n, RT);
        chk("R7 latch cleared", rcl_pend, 0);
        chk("R7 dirty cleared", dirty, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule